// File: doc/BRIEF.md
# Predicated Instruction Condition Evaluator

This block decides, for every instruction issued into a small wide-issue datapath, whether that instruction is allowed to commit. Each instruction carries a three-bit predicate selector and a one-bit invert flag. The selector either marks the instruction as unconditional or names one of five condition registers: three from the B bank and two from the A bank. The block tests the named register against zero, applies the invert flag, and produces a commit enable. That enable gates every writeback path, not only branches. A branch-taken strobe is derived from it.

The block keeps its own shadow copy of the five condition registers. The shadows are fed from the datapath writeback port, and writes to any other register are discarded. The predicate is always evaluated against the value held at issue time. A writeback that lands in the same cycle as the issue is deliberately not forwarded. A typical use is a countdown loop: an instruction decrements a counter register, and a branch predicated on that register jumps back while the counter is still nonzero.

Top module: `pred_eval`

## Requirements
- R1: With selector 000 and invert flag 0 the instruction is unconditional: commit_en is 1 for every issued instruction.
- R2: With invert flag 0 and a register selector, commit_en is 1 only if the selected condition register holds a nonzero value.
- R3: With invert flag 1 and a register selector, commit_en is 1 only if the selected condition register is zero.
- R4: Selector codes map as follows: 001 = B0, 010 = B1, 011 = B2, 100 = A1, 101 = A2.
- R5: Selectors 110 and 111, and selector 000 with invert flag 1, are illegal. They raise pred_illegal and force commit_en to 0.
- R6: branch_taken is 1 exactly when commit_en is 1 and the issued instruction had is_branch set.
- R7: commit_en, branch_taken and pred_illegal are registered: they show the result for an instruction issued in cycle t during cycle t+1. When issue_valid is 0, all three are 0 in the following cycle.
- R8: A writeback with wr_en=1, bank flag wr_bank_b (1 = B bank, 0 = A bank) and index wr_idx updates the matching condition shadow at the clock edge. An instruction issued in that same cycle still sees the old value, and the next issue sees the new one.
- R9: Writebacks whose bank and index do not name one of the five condition registers (for example A0, A6 or B8) change no condition shadow.
- R10: Synchronous active-high reset clears all condition shadows to zero and all three outputs to 0.
- R11: A countdown loop that starts at N (N >= 1) and decrements the counter before each branch predicated on it yields exactly N-1 taken branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is issued this cycle |
| pred_sel | input | 3 | Predicate register selector |
| pred_inv | input | 1 | Invert flag: 1 means commit when the register is zero |
| is_branch | input | 1 | Issued instruction is a branch |
| wr_en | input | 1 | Writeback valid |
| wr_bank_b | input | 1 | Writeback bank: 1 = B, 0 = A |
| wr_idx | input | IDX_W | Writeback register index |
| wr_data | input | DATA_W | Writeback data |
| commit_en | output | 1 | Issued instruction commits (registered) |
| branch_taken | output | 1 | Committing branch (registered) |
| pred_illegal | output | 1 | Illegal predicate encoding (registered) |

## Verification
Each of the three results belongs to the instruction issued one edge earlier. The bench drives inputs on the falling edge and samples shortly after the next rising edge, so every check reads the result of exactly one issue. A writeback takes effect at that same edge, so the effect of a write can only appear in an issue made one cycle later. The non-forwarding check therefore issues in the write cycle and again in the cycle after it, and expects different answers. The countdown loop pairs each decrement with a branch in the next cycle and counts taken strobes against N-1.

// File: rtl/pred_pkg.sv
package pred_pkg;
  localparam int SEL_W    = 3;
  localparam int NUM_COND = 5;

  // Selector encoding; slot s is selected by code s+1.
  typedef enum logic [SEL_W-1:0] {
    SEL_ALWAYS = 3'd0,
    SEL_B0     = 3'd1,
    SEL_B1     = 3'd2,
    SEL_B2     = 3'd3,
    SEL_A1     = 3'd4,
    SEL_A2     = 3'd5
  } sel_code_e;

  // Slots 0..2 live in bank B (index 0..2), slots 3..4 in bank A (index 1..2).
  function automatic logic slot_in_b(input int s);
    return (s < 3);
  endfunction

  function automatic int slot_index(input int s);
    return (s < 3) ? s : s - 2;
  endfunction
endpackage

// File: rtl/pred_cond_bank.sv
module pred_cond_bank
  import pred_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                wr_bank_b,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [NUM_COND-1:0] nonzero
);
  for (genvar s = 0; s < NUM_COND; s++) begin : g_slot
    localparam logic             IN_B = slot_in_b(s);
    localparam logic [IDX_W-1:0] IDX  = IDX_W'(slot_index(s));
    logic [DATA_W-1:0] shadow_q;
    logic              hit;

    assign hit = wr_en && (wr_bank_b == IN_B) && (wr_idx == IDX);

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_q <= '0;
      end else if (hit) begin
        shadow_q <= wr_data;
      end
    end

    assign nonzero[s] = |shadow_q;
  end
endmodule

// File: rtl/pred_sel_decode.sv
module pred_sel_decode
  import pred_pkg::*;
(
  input  logic [SEL_W-1:0]    sel,
  input  logic                inv,
  output logic [NUM_COND-1:0] slot_hot,
  output logic                uncond,
  output logic                illegal
);
  always_comb begin
    for (int s = 0; s < NUM_COND; s++) begin
      slot_hot[s] = (sel == SEL_W'(s + 1));
    end
    uncond  = (sel == SEL_ALWAYS) && !inv;
    illegal = ((sel == SEL_ALWAYS) && inv) || (sel > SEL_W'(NUM_COND));
  end
endmodule

// File: rtl/pred_eval.sv
module pred_eval
  import pred_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [2:0]        pred_sel,
  input  logic              pred_inv,
  input  logic              is_branch,
  input  logic              wr_en,
  input  logic              wr_bank_b,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              commit_en,
  output logic              branch_taken,
  output logic              pred_illegal
);
  logic [NUM_COND-1:0] nonzero;
  logic [NUM_COND-1:0] slot_hot;
  logic                uncond;
  logic                illegal;
  logic                cond_true;
  logic                commit_d;

  pred_cond_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_bank_b (wr_bank_b),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .nonzero   (nonzero)
  );

  pred_sel_decode u_dec (
    .sel      (pred_sel),
    .inv      (pred_inv),
    .slot_hot (slot_hot),
    .uncond   (uncond),
    .illegal  (illegal)
  );

  // Shadows are read before this edge's writeback lands: no forwarding.
  assign cond_true = uncond || ((|(slot_hot & nonzero)) ^ pred_inv);
  assign commit_d  = issue_valid && !illegal && cond_true;

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_en    <= 1'b0;
      branch_taken <= 1'b0;
      pred_illegal <= 1'b0;
    end else begin
      commit_en    <= commit_d;
      branch_taken <= commit_d && is_branch;
      pred_illegal <= issue_valid && illegal;
    end
  end
endmodule

// File: rtl/pred_eval_chk.sv
module pred_eval_chk (
  input logic       clk,
  input logic       rst,
  input logic       issue_valid,
  input logic [2:0] pred_sel,
  input logic       pred_inv,
  input logic       is_branch,
  input logic       commit_en,
  input logic       branch_taken,
  input logic       pred_illegal
);
  p_uncond_commit_r1: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && pred_sel == 3'd0 && !pred_inv) |=> commit_en);

  p_illegal_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && (pred_sel >= 3'd6 || (pred_sel == 3'd0 && pred_inv)))
      |=> (pred_illegal && !commit_en));

  p_illegal_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    pred_illegal |-> !commit_en);

  p_nonbranch_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !is_branch) |=> !branch_taken);

  p_branch_needs_commit_r6: assert property (@(posedge clk) disable iff (rst)
    branch_taken |-> commit_en);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> (!commit_en && !branch_taken && !pred_illegal));
endmodule

bind pred_eval pred_eval_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .issue_valid  (issue_valid),
  .pred_sel     (pred_sel),
  .pred_inv     (pred_inv),
  .is_branch    (is_branch),
  .commit_en    (commit_en),
  .branch_taken (branch_taken),
  .pred_illegal (pred_illegal)
);

// File: tb/pred_eval_bench.sv
`timescale 1ns/1ps
module pred_eval_bench;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 4;
  localparam int NVEC   = 13;
  // {sel[2:0], inv, is_branch, exp_commit, exp_branch, exp_illegal}
  // Shadows during the table: B0=0, B1=5, B2=0, A1=7, A2=0.
  localparam logic [7:0] VEC [NVEC] = '{
    8'b000_0_1_110,  // R1 unconditional branch
    8'b000_1_0_001,  // R5 000 with invert is illegal
    8'b001_0_0_000,  // R2 R4 B0=0
    8'b001_1_1_110,  // R3 R4 !B0
    8'b010_0_0_100,  // R2 R4 B1=5
    8'b010_1_0_000,  // R3 !B1
    8'b011_1_1_110,  // R3 R4 !B2
    8'b100_0_1_110,  // R2 R4 A1=7
    8'b100_1_0_000,  // R3 !A1
    8'b101_0_0_000,  // R2 R4 A2=0
    8'b101_1_0_100,  // R3 !A2
    8'b110_0_1_001,  // R5 code 110
    8'b111_1_0_001   // R5 code 111
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              issue_valid = 1'b0;
  logic [2:0]        pred_sel = '0;
  logic              pred_inv = 1'b0;
  logic              is_branch = 1'b0;
  logic              wr_en = 1'b0;
  logic              wr_bank_b = 1'b0;
  logic [IDX_W-1:0]  wr_idx = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              commit_en, branch_taken, pred_illegal;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pred_eval #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_pred_eval (
    .clk          (clk),
    .rst          (rst),
    .issue_valid  (issue_valid),
    .pred_sel     (pred_sel),
    .pred_inv     (pred_inv),
    .is_branch    (is_branch),
    .wr_en        (wr_en),
    .wr_bank_b    (wr_bank_b),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data),
    .commit_en    (commit_en),
    .branch_taken (branch_taken),
    .pred_illegal (pred_illegal)
  );

  task automatic check3(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {commit_en, branch_taken, pred_illegal};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {commit,branch,illegal} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // One cycle: drive on the falling edge, sample 1 ns after the rising edge.
  task automatic cycle(input logic iv, input logic [2:0] sel, input logic inv,
                       input logic br, input logic we, input logic bb,
                       input logic [IDX_W-1:0] idx, input logic [DATA_W-1:0] d);
    @(negedge clk);
    issue_valid = iv; pred_sel = sel; pred_inv = inv; is_branch = br;
    wr_en = we; wr_bank_b = bb; wr_idx = idx; wr_data = d;
    @(posedge clk);
    #1;
  endtask

  task automatic write_reg(input logic bb, input logic [IDX_W-1:0] idx,
                           input logic [DATA_W-1:0] d);
    cycle(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, bb, idx, d);
  endtask

  initial begin
    int taken;
    int passes;
    int cnt;
    // R10: reset state
    repeat (3) @(posedge clk);
    #1;
    check3("R10 outputs in reset", 3'b000);
    @(negedge clk);
    rst = 1'b0;
    cycle(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
    check3("R7 idle gives zero", 3'b000);
    // R10: shadows cleared -> !B1 commits
    cycle(1'b1, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, '0, '0);
    check3("R10 B1 cleared by reset", 3'b100);

    write_reg(1'b1, 4'd1, 32'd5);   // B1 = 5
    write_reg(1'b0, 4'd1, 32'd7);   // A1 = 7
    for (int i = 0; i < NVEC; i++) begin
      cycle(1'b1, VEC[i][7:5], VEC[i][4], VEC[i][3], 1'b0, 1'b0, '0, '0);
      check3($sformatf("R1-5 vector %0d (R2 R3 R4 R5 R6)", i), VEC[i][2:0]);
    end
    // R7: result visible exactly one cycle, then idle zeroes it
    cycle(1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0);
    check3("R7 one cycle after issue", 3'b110);
    cycle(1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0);
    check3("R7 no issue, no result", 3'b000);

    // R8: B0 is 0; write 3 in the issue cycle, not forwarded
    cycle(1'b1, 3'd1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd0, 32'd3);
    check3("R8 same-cycle write not forwarded", 3'b000);
    cycle(1'b1, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0);
    check3("R8 write visible next issue", 3'b110);

    // R9: writes to non-condition registers are dropped
    write_reg(1'b0, 4'd6, 32'd1);   // A6 (aliases A2 in low bits)
    write_reg(1'b0, 4'd0, 32'd1);   // A0
    cycle(1'b1, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, '0, '0);
    check3("R9 A2 untouched by A6/A0 writes", 3'b100);
    write_reg(1'b1, 4'd8, 32'd0);   // B8 (aliases B0 in low bits)
    write_reg(1'b1, 4'd3, 32'd0);   // B3
    cycle(1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
    check3("R9 B0 untouched by B8/B3 writes", 3'b100);

    // R11: countdown loop on B1 from N=5
    cnt = 5; taken = 0; passes = 0;
    write_reg(1'b1, 4'd1, 32'(cnt));
    while (passes < 20) begin
      cnt--;
      passes++;
      cycle(1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1, 32'(cnt));  // decrement
      cycle(1'b1, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0);          // [B1] branch
      if (branch_taken) taken++;
      else break;
    end
    checks++;
    if (taken != 4) begin
      failures++;
      $display("FAIL R11: taken branches actual=%0d expected=%0d", taken, 4);
    end
    checks++;
    if (passes != 5) begin
      failures++;
      $display("FAIL R11: loop passes actual=%0d expected=%0d", passes, 5);
    end

    // R10: reset mid-run clears A1 (was 7)
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check3("R10 outputs cleared by reset", 3'b000);
    @(negedge clk);
    rst = 1'b0;
    cycle(1'b1, 3'd4, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0);
    check3("R10 A1 cleared by reset", 3'b110);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule